// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. The segment is moved four bit positions up and the offset is added to it. The block holds the four segment registers and the instruction pointer. For each request it picks the segment and the offset from the kind of access, so the code that issues requests only says what sort of access it is making.

A request carries an access kind and the pointer values that the execution side already holds: stack pointer, base pointer, destination index and a generic data offset. The block chooses one segment register and one offset for the request. The address comes out registered, one cycle later, together with a valid flag. Segment registers are loaded through a write port. The instruction pointer can be loaded directly, and it steps by one for every code byte consumed. A step past FFFF wraps to 0000 and leaves the code segment unchanged. A carry out of the top address bit is dropped, so every address stays inside the 1 MB space and no segment reaches past 64 KB.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address is the 20-bit truncated sum of the segment value shifted left by four and the zero-extended offset. Segment 34BA with offset 8AB4 gives 3D654.
- R2: Access kind code 0 (instruction fetch) uses the code segment register with the current instruction pointer as the offset.
- R3: Access kind code 1 (stack push/pop) uses the stack segment register with `sp_off`.
- R4: Access kind code 2 (based stack access) uses the stack segment register with `bp_off`.
- R5: Access kind code 3 (string destination) uses the extra segment register with `di_off`.
- R6: Access kind code 4 (data), and the unused codes 5 to 7, use the data segment register with `data_off`.
- R7: `addr_valid` is high in the cycle after each cycle with `acc_valid` high and low otherwise. The address is formed from the register values held before that clock edge, so a segment write or pointer change in the same cycle is not yet seen.
- R8: With `seg_wr_en` high, `seg_wr_data` is written into the segment register chosen by `seg_wr_sel` (0 extra, 1 code, 2 stack, 3 data). It takes effect from the next cycle, and the other three registers keep their values.
- R9: With `ip_step` high and `ip_load` low, the instruction pointer increases by one. It wraps from FFFF to 0000 without touching the code segment. With neither `ip_step` nor `ip_load` high, it holds its value.
- R10: With `ip_load` high, the instruction pointer takes `ip_load_val` on the next edge, even if `ip_step` is high in the same cycle.
- R11: A sum above FFFFF wraps. Segment FFFF with offset 0010 gives 00000, and with offset FFFF it gives 0FFEF.
- R12: A synchronous active-low reset clears all segment registers and the instruction pointer to zero and holds `addr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write: 0 extra, 1 code, 2 stack, 3 data |
| seg_wr_data | input | 16 | Value to write into the chosen segment register |
| ip_load | input | 1 | Load the instruction pointer |
| ip_load_val | input | 16 | Value for the instruction pointer load |
| ip_step | input | 1 | One code byte consumed; step the instruction pointer |
| acc_valid | input | 1 | Address request |
| acc_kind | input | 3 | Access kind: 0 fetch, 1 stack SP, 2 stack BP, 3 string destination, 4 to 7 data |
| sp_off | input | 16 | Stack pointer offset |
| bp_off | input | 16 | Base pointer offset |
| di_off | input | 16 | Destination index offset |
| data_off | input | 16 | Generic data offset |
| addr_valid | output | 1 | Physical address valid |
| phys_addr | output | 20 | Physical address |
| ip_value | output | 16 | Current instruction pointer |

## Verification
The bench drives every pointer input that a request does not use with a decoy value. A design that wires the wrong offset or the wrong segment to an access kind therefore produces an address that cannot match the expected one. The wrap cases are checked directly: segment FFFF with offsets 0010 and FFFF, and the instruction pointer stepping across FFFF. A design that carried into a 21st bit, or that bumped the code segment on pointer overflow, would produce a wrong fetch address after the wrap. A segment write in the same cycle as a request must not yet be seen, and a load must win over a step. A design that bypassed the write or let the step win would be one value off. Idle cycles are watched for stray valid pulses.

// File: rtl/seg_addr_pkg.sv
// Package: shared widths and encodings for the segmented address generator.
// Assumes the segment and offset are the same width and the shift is 4.
package seg_addr_pkg;
    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int NSEG   = 4;
    localparam int SEL_W  = $clog2(NSEG);
    localparam int PA_W   = SEG_W + SHIFT;
    localparam int KIND_W = 3;

    // Segment register slots; the index is the write-select code.
    typedef enum logic [SEL_W-1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_sel_e;

    // Access kinds; codes above KIND_DATA fall back to data.
    typedef enum logic [KIND_W-1:0] {
        KIND_FETCH  = 3'd0,
        KIND_STK_SP = 3'd1,
        KIND_STK_BP = 3'd2,
        KIND_STR_DS = 3'd3,
        KIND_DATA   = 3'd4
    } acc_kind_e;
endpackage

// File: rtl/seg_bank.sv
// Module: seg_bank
// Holds the segment registers. Each slot is loaded when the write strobe
// is high and the select matches the slot. Assumes one write per cycle.
module seg_bank
    import seg_addr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [SEG_W-1:0]            wr_data,
    output logic [NSEG-1:0][SEG_W-1:0]  seg_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_slot
        // One register per slot: clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                seg_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/ip_counter.sv
// Module: ip_counter
// Instruction pointer. A load wins over a step, and a step wraps modulo
// 2^OFF_W. Assumes one step per consumed code byte.
module ip_counter
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [OFF_W-1:0] ld_val,
    input  logic             step,
    output logic [OFF_W-1:0] ip_q
);
    // Pointer update: reset, load, step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ip_q <= '0;
        else if (ld)
            ip_q <= ld_val;
        else if (step)
            ip_q <= ip_q + OFF_W'(1);
    end
endmodule

// File: rtl/addr_mux.sv
// Module: addr_mux
// Picks the default segment and the offset source from the access kind.
// Purely combinational. Unknown kinds are treated as data accesses.
module addr_mux
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0]           kind,
    input  logic [NSEG-1:0][SEG_W-1:0]  seg_q,
    input  logic [OFF_W-1:0]            ip,
    input  logic [OFF_W-1:0]            sp,
    input  logic [OFF_W-1:0]            bp,
    input  logic [OFF_W-1:0]            di,
    input  logic [OFF_W-1:0]            data,
    output logic [SEG_W-1:0]            seg_sel,
    output logic [OFF_W-1:0]            off_sel
);
    // Default segment and offset for each access kind.
    always_comb begin
        unique case (kind)
            KIND_FETCH:  begin seg_sel = seg_q[SEG_CODE];  off_sel = ip; end
            KIND_STK_SP: begin seg_sel = seg_q[SEG_STACK]; off_sel = sp; end
            KIND_STK_BP: begin seg_sel = seg_q[SEG_STACK]; off_sel = bp; end
            KIND_STR_DS: begin seg_sel = seg_q[SEG_EXTRA]; off_sel = di; end
            default:     begin seg_sel = seg_q[SEG_DATA];  off_sel = data; end
        endcase
    end
endmodule

// File: rtl/addr_adder.sv
// Module: addr_adder
// Shift-and-add stage with a registered result. Any carry past the top
// address bit is dropped, so addresses wrap inside the PA_W space.
module addr_adder
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic             out_valid,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] sum;

    // Align the segment to a 16-byte boundary and add the offset.
    always_comb begin
        sum = (PA_W'(seg) << SHIFT) + PA_W'(off);
    end

    // Output register: valid follows the request, address captured with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            phys      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                phys <= sum;
        end
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Segmented physical address generator. Holds the segment registers and
// the instruction pointer, picks the default segment for each access
// kind, and returns a registered 20-bit address one cycle later.
// Assumes the pointer inputs are stable in the request cycle.
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [15:0]       seg_wr_data,
    input  logic              ip_load,
    input  logic [15:0]       ip_load_val,
    input  logic              ip_step,
    input  logic              acc_valid,
    input  logic [2:0]        acc_kind,
    input  logic [15:0]       sp_off,
    input  logic [15:0]       bp_off,
    input  logic [15:0]       di_off,
    input  logic [15:0]       data_off,
    output logic              addr_valid,
    output logic [19:0]       phys_addr,
    output logic [15:0]       ip_value
);
    logic [NSEG-1:0][SEG_W-1:0] seg_q;
    logic [OFF_W-1:0]           ip_q;
    logic [SEG_W-1:0]           seg_pick;
    logic [OFF_W-1:0]           off_pick;

    seg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    ip_counter u_ip (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ip_load),
        .ld_val (ip_load_val),
        .step   (ip_step),
        .ip_q   (ip_q)
    );

    addr_mux u_mux (
        .kind    (acc_kind),
        .seg_q   (seg_q),
        .ip      (ip_q),
        .sp      (sp_off),
        .bp      (bp_off),
        .di      (di_off),
        .data    (data_off),
        .seg_sel (seg_pick),
        .off_sel (off_pick)
    );

    addr_adder u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_valid),
        .seg       (seg_pick),
        .off       (off_pick),
        .out_valid (addr_valid),
        .phys      (phys_addr)
    );

    assign ip_value = ip_q;
endmodule

// File: rtl/seg_addr_gen_chk.sv
// Module: seg_addr_gen_chk
// Checker for seg_addr_gen, bound to every instance of the top module.
// It watches the ports and the segment register outputs.
module seg_addr_gen_chk
    import seg_addr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        seg_wr_en,
    input  logic [SEL_W-1:0]            seg_wr_sel,
    input  logic [SEG_W-1:0]            seg_wr_data,
    input  logic                        ip_load,
    input  logic [OFF_W-1:0]            ip_load_val,
    input  logic                        ip_step,
    input  logic                        acc_valid,
    input  logic [KIND_W-1:0]           acc_kind,
    input  logic                        addr_valid,
    input  logic [PA_W-1:0]             phys_addr,
    input  logic [OFF_W-1:0]            ip_value,
    input  logic [NSEG-1:0][SEG_W-1:0]  seg_q
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (ip_value == '0) && !addr_valid && (seg_q == '0)); // R12

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> addr_valid); // R7

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !addr_valid); // R7

    AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_step && !ip_load) |=> ip_value == $past(ip_value) + OFF_W'(1)); // R9

    AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip_step && !ip_load) |=> $stable(ip_value)); // R9

    AST_IP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> ip_value == $past(ip_load_val)); // R10

    AST_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |=> seg_q[$past(seg_wr_sel)] == $past(seg_wr_data)); // R8

    AST_SEG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_wr_en |=> $stable(seg_q)); // R8

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == KIND_FETCH) |=>
        phys_addr == (PA_W'($past(seg_q[SEG_CODE])) << SHIFT) + PA_W'($past(ip_value))); // R2
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_wr_en   (seg_wr_en),
    .seg_wr_sel  (seg_wr_sel),
    .seg_wr_data (seg_wr_data),
    .ip_load     (ip_load),
    .ip_load_val (ip_load_val),
    .ip_step     (ip_step),
    .acc_valid   (acc_valid),
    .acc_kind    (acc_kind),
    .addr_valid  (addr_valid),
    .phys_addr   (phys_addr),
    .ip_value    (ip_value),
    .seg_q       (seg_q)
);

// File: tb/seg_addr_gen_tb.sv
// Scoreboard bench for seg_addr_gen. The driver keeps its own model of the
// segment registers and the instruction pointer and queues expected
// addresses. The monitor pops and compares them as addr_valid appears.
module seg_addr_gen_tb;
    localparam int CLK_HALF = 10; // 50 MHz
    localparam logic [2:0] K_FETCH = 3'd0, K_SP = 3'd1, K_BP = 3'd2,
                           K_DI = 3'd3, K_DATA = 3'd4, K_ODD = 3'd7;
    localparam logic [15:0] DECOY = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = 2'd0;
    logic [15:0] seg_wr_data = 16'h0;
    logic        ip_load = 1'b0;
    logic [15:0] ip_load_val = 16'h0;
    logic        ip_step = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_kind = 3'd0;
    logic [15:0] sp_off = 16'h0, bp_off = 16'h0, di_off = 16'h0, data_off = 16'h0;
    logic        addr_valid;
    logic [19:0] phys_addr;
    logic [15:0] ip_value;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] m_seg [4];
    logic [15:0] m_ip;
    logic [19:0] exp_q [$];
    string       tag_q [$];

    seg_addr_gen u_dut (.*);

    always #(CLK_HALF) clk = ~clk;

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One-cycle stimulus: set at negedge, update the model, clear after the edge.
    task automatic drive(input logic wr, input logic [1:0] sel, input logic [15:0] wdat,
                         input logic ld, input logic [15:0] ldv, input logic stp,
                         input logic req, input logic [2:0] kind, input logic [15:0] off,
                         input string tag);
        @(negedge clk);
        seg_wr_en = wr; seg_wr_sel = sel; seg_wr_data = wdat;
        ip_load = ld; ip_load_val = ldv; ip_step = stp;
        acc_valid = req; acc_kind = kind;
        sp_off = (kind == K_SP) ? off : DECOY;
        bp_off = (kind == K_BP) ? off : DECOY;
        di_off = (kind == K_DI) ? off : DECOY;
        data_off = (kind >= K_DATA) ? off : DECOY;
        if (req) begin
            case (kind)
                K_FETCH: exp_q.push_back(pa(m_seg[1], m_ip));
                K_SP, K_BP: exp_q.push_back(pa(m_seg[2], off));
                K_DI:    exp_q.push_back(pa(m_seg[0], off));
                default: exp_q.push_back(pa(m_seg[3], off));
            endcase
            tag_q.push_back(tag);
        end
        if (wr) m_seg[sel] = wdat;
        if (ld) m_ip = ldv;
        else if (stp) m_ip = m_ip + 16'd1;
        @(posedge clk);
        #1;
        seg_wr_en = 1'b0; ip_load = 1'b0; ip_step = 1'b0; acc_valid = 1'b0;
    endtask

    task automatic req(input logic [2:0] kind, input logic [15:0] off, input string tag);
        drive(1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, kind, off, tag);
    endtask

    task automatic wseg(input logic [1:0] sel, input logic [15:0] v);
        drive(1'b1, sel, v, 1'b0, 16'h0, 1'b0, 1'b0, K_DATA, 16'h0, "R8");
    endtask

    // Called right after drive (posedge+1): sample the pointer at posedge+5.
    task automatic check_ip(input string tag);
        #4;
        check(tag, 32'(ip_value), 32'(m_ip));
    endtask

    // Monitor: pop and compare on each valid address; flag stray valids (R7).
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && addr_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 stray addr_valid", 32'(addr_valid), 32'd0);
                end else begin
                    check(tag_q.pop_front(), 32'(phys_addr), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_HALF * 2 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
        m_ip = 16'h0;
        repeat (4) @(posedge clk);
        #5;
        check("R12 valid low in reset", 32'(addr_valid), 32'd0);
        check("R12 ip zero in reset", 32'(ip_value), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        req(K_FETCH, 16'h0, "R12 R2 fetch after reset");
        wseg(2'd3, 16'h34BA);
        wseg(2'd1, 16'h1234);
        wseg(2'd2, 16'h2000);
        wseg(2'd0, 16'hF000);
        req(K_DATA, 16'h8AB4, "R1 R6 data 34BA:8AB4");
        req(K_ODD, 16'h0001, "R6 unused kind as data");

        drive(1'b0, 2'd0, 16'h0, 1'b1, 16'h0010, 1'b0, 1'b0, K_DATA, 16'h0, "");
        check_ip("R10 ip load");
        req(K_FETCH, 16'h0, "R2 fetch CS:IP");

        // back-to-back kinds (R7)
        req(K_SP, 16'hFFFE, "R3 stack SP");
        req(K_BP, 16'h0100, "R4 stack BP");
        req(K_DI, 16'h1234, "R5 string dest");

        wseg(2'd0, 16'hFFFF);
        req(K_DI, 16'h0010, "R11 wrap to zero");
        req(K_DI, 16'hFFFF, "R11 wrap top");
        req(K_DATA, 16'h8AB4, "R8 data seg kept after extra write");

        // write and request in the same cycle: old segment used (R7)
        drive(1'b1, 2'd3, 16'h1000, 1'b0, 16'h0, 1'b0, 1'b1, K_DATA, 16'h0000,
              "R7 same-cycle write not seen");
        req(K_DATA, 16'h0000, "R8 new data segment");

        drive(1'b0, 2'd0, 16'h0, 1'b1, 16'hFFFE, 1'b0, 1'b0, K_DATA, 16'h0, "");
        drive(1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, K_DATA, 16'h0, "");
        drive(1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, K_DATA, 16'h0, "");
        check_ip("R9 ip at FFFF->0000 boundary");
        drive(1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, K_DATA, 16'h0, "");
        check_ip("R9 ip after wrap");
        drive(1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b1, K_FETCH, 16'h0,
              "R9 fetch with step uses old IP, CS kept");
        check_ip("R9 ip step during fetch");
        req(K_FETCH, 16'h0, "R9 fetch after step");
        drive(1'b0, 2'd0, 16'h0, 1'b1, 16'h5555, 1'b1, 1'b0, K_DATA, 16'h0, "");
        check_ip("R10 load beats step");
        repeat (2) @(negedge clk);
        check_ip("R9 ip holds when idle");

        repeat (5) @(negedge clk);
        check("R7 all expected addresses seen", 32'(exp_q.size()), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule